// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Controller

This block gives a processor a register window onto a nonvolatile byte array. The processor sees four byte registers, chosen by a two-bit select. Two of them hold the array address, split into a low byte and a high part. One is a data byte. One is a control byte that holds three flags: arm, write-go/busy and read-go.

A store needs two steps. Software first sets the arm flag. While the arm flag is still live, software sets write-go. The controller then copies the address and the data into its own write engine and keeps the busy flag high for a programmable number of clocks. The array byte changes in the cycle in which busy drops. A load is started with read-go. The addressed byte then lands in the data register, and the processor reads it there.

Software polls busy and waits for it to read zero before it starts a new access. The controller enforces this itself: while busy is high it ignores loads and ignores writes to the address and data registers. A store that is under way is not stopped by the synchronous reset. The write engine keeps its own copy of the target and runs to completion. The cell array is modelled as a synchronous RAM with a write-latency counter in front of it.

Top module: `nvm_ctrl`

## Requirements
- R1: With no store in progress, reset clears the address, the data register and every control flag, so all of them read back as zero.
- R2: Select 0 writes the low 8 address bits. Select 1 writes the upper ADDR_W-8 bits from the low bits of the byte, and the unused high bits read back as zero.
- R3: Writing control bit 2 sets the arm flag, which reads back on bit 2. The flag clears by itself once ARM_WINDOW (4) clocks have passed after the write that set it.
- R4: A control write that has bit 1 set launches a store only when the arm flag is live, bit 2 is clear in that same write, and no store is in progress. The launch clears the arm flag. A bit-1 write without a live arm flag has no effect, and so does a write that sets bits 1 and 2 together.
- R5: After a launch, control bit 1 (busy) reads 1 for exactly WRITE_CYCLES clocks and then clears. The array byte is updated at the moment busy clears.
- R6: A control write with bit 0 set, while no store is in progress, loads the data register (select 2) with the addressed array byte. The byte can be read two cycles after the strobe. Bit 0 reads 1 for the single cycle in between.
- R7: A read strobe given while busy is ignored, and the data register keeps its value.
- R8: Writes to the address and data registers are ignored while busy.
- R9: A store in progress keeps running through a synchronous reset. Busy stays visible after the reset, and the array holds the stored byte once busy clears.
- R10: A bus read returns the selected register (0 low address, 1 high address, 2 data, 3 control) in the cycle after bus_re.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not stop a store already under way |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data |

## Verification
Directed sequences place the write-go strobe one cycle inside the arm window and one cycle past it. They also set arm and write-go in the same byte, and give write-go with no arm at all; together these separate a correct unlock from one that is too loose or too strict. Busy is sampled in its last high cycle and in its first low cycle, which exposes an off-by-one in the write timer. Loads, data writes and address writes are issued in the middle of a store to show they are dropped, and a reset pulse in the middle of a store shows the write still finishes. Random addresses and bytes are then stored and loaded back against a bench model of the array, so that aliasing between the address bytes shows up as a mismatch.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_CTRL    = 2'd3
  } nvm_sel_e;

  localparam int BIT_RD  = 0;
  localparam int BIT_WR  = 1;
  localparam int BIT_ARM = 2;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int WINDOW = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_set,
  input  logic consume,
  output logic live
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || consume) begin
      cnt_q <= '0;
    end else if (arm_set) begin
      cnt_q <= CW'(WINDOW);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign live = (cnt_q != '0);
endmodule

// File: rtl/nvm_write_timer.sv
module nvm_write_timer #(
  parameter int CYCLES = 20,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              launch,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [7:0]        data_in,
  output logic              busy,
  output logic              commit,
  output logic [ADDR_W-1:0] c_addr,
  output logic [7:0]        c_data
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  // Power-up values only: this engine deliberately ignores the bus reset.
  logic              busy_q = 1'b0;
  logic [CW-1:0]     cnt_q  = '0;
  logic [ADDR_W-1:0] addr_q = '0;
  logic [7:0]        data_q = '0;

  always_ff @(posedge clk) begin
    if (launch && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
      addr_q <= addr_in;
      data_q <= data_in;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy   = busy_q;
  assign commit = busy_q && (cnt_q == '0);
  assign c_addr = addr_q;
  assign c_data = data_q;
endmodule

// File: rtl/nvm_cell_array.sv
module nvm_cell_array #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rq <= mem[raddr];
  end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 20,
  parameter int ARM_WINDOW   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic       bus_re,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int HI_W = ADDR_W - 8;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              rd_pend;
  logic [7:0]        rdata_q;

  logic              arm_live;
  logic              wr_busy;
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [7:0]        mem_q;

  logic ctrl_wr, arm_set, launch, rd_go, idle_wr;
  logic [7:0] ctrl_view;

  always_comb begin
    ctrl_wr = bus_we && (bus_sel == SEL_CTRL) && !rst;
    arm_set = ctrl_wr && bus_wdata[BIT_ARM];
    launch  = ctrl_wr && bus_wdata[BIT_WR] && !bus_wdata[BIT_ARM] && arm_live && !wr_busy;
    rd_go   = ctrl_wr && bus_wdata[BIT_RD] && !wr_busy && !launch;
    idle_wr = bus_we && !wr_busy;
  end

  nvm_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
    .clk     (clk),
    .rst     (rst),
    .arm_set (arm_set),
    .consume (launch),
    .live    (arm_live)
  );

  nvm_write_timer #(.CYCLES(WRITE_CYCLES), .ADDR_W(ADDR_W)) u_timer (
    .clk     (clk),
    .launch  (launch),
    .addr_in (addr_q),
    .data_in (data_q),
    .busy    (wr_busy),
    .commit  (wr_commit),
    .c_addr  (wr_addr),
    .c_data  (wr_data)
  );

  nvm_cell_array #(.ADDR_W(ADDR_W)) u_cells (
    .clk   (clk),
    .we    (wr_commit),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (addr_q),
    .rq    (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (idle_wr && bus_sel == SEL_ADDR_LO) begin
      addr_q[7:0] <= bus_wdata;
    end else if (idle_wr && bus_sel == SEL_ADDR_HI) begin
      addr_q[ADDR_W-1:8] <= bus_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      data_q  <= '0;
    end else begin
      rd_pend <= rd_go;
      if (rd_pend) begin
        data_q <= mem_q;
      end else if (idle_wr && bus_sel == SEL_DATA) begin
        data_q <= bus_wdata;
      end
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[BIT_RD]  = rd_pend;
    ctrl_view[BIT_WR]  = wr_busy;
    ctrl_view[BIT_ARM] = arm_live;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_re) begin
      case (bus_sel)
        SEL_ADDR_LO: rdata_q <= addr_q[7:0];
        SEL_ADDR_HI: rdata_q <= 8'(addr_q[ADDR_W-1:8]);
        SEL_DATA:    rdata_q <= data_q;
        default:     rdata_q <= ctrl_view;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
  parameter int ADDR_W       = 9,
  parameter int WRITE_CYCLES = 20,
  parameter int ARM_WINDOW   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              arm_live,
  input logic              commit,
  input logic [ADDR_W-1:0] addr_q,
  input logic              rd_pend
);
  int busy_run = 0;
  int arm_run  = 0;

  always_ff @(posedge clk) begin
    busy_run <= busy ? busy_run + 1 : 0;
    if (rst || !arm_live) arm_run <= 0;
    else arm_run <= arm_run + 1;
  end

  assert_arm_window_R3: assert property (@(posedge clk) disable iff (rst)
    arm_live |-> (arm_run < ARM_WINDOW));

  assert_launch_armed_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(arm_live) && !$past(rst)));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < WRITE_CYCLES));

  assert_commit_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    commit |-> (busy_run == WRITE_CYCLES - 1));

  assert_commit_drops_busy_R5: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy);

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_pend) |-> !$past(busy));

  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> $stable(addr_q));
endmodule

bind nvm_ctrl nvm_ctrl_chk #(
  .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES), .ARM_WINDOW(ARM_WINDOW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (wr_busy),
  .arm_live (arm_live),
  .commit   (wr_commit),
  .addr_q   (addr_q),
  .rd_pend  (rd_pend)
);

// File: tb/tb_nvm_ctrl.sv
`timescale 1ns/100ps
module tb_nvm_ctrl;
  localparam int AW = 9;
  localparam int WC = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [1<<AW];

  always #2.5 clk = ~clk;

  nvm_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ARM_WINDOW(4)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] ctrl_exp(bit arm, bit busy, bit rd);
    return {5'b0, arm, busy, rd};
  endfunction

  function automatic logic [7:0] hi_exp(logic [AW-1:0] a);
    return 8'(a >> 8);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic [1:0] s, logic [7:0] d);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] s, output logic [7:0] d);
    bus_re = 1'b1; bus_sel = s;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_addr(logic [AW-1:0] a);
    bus_wr(2'd0, a[7:0]);
    bus_wr(2'd1, hi_exp(a));
  endtask

  task automatic launch_store(logic [AW-1:0] a, logic [7:0] d);
    set_addr(a);
    bus_wr(2'd2, d);
    bus_wr(2'd3, 8'h04);
    bus_wr(2'd3, 8'h02);
    model[a] = d;
  endtask

  task automatic load(logic [AW-1:0] a, output logic [7:0] d);
    set_addr(a);
    bus_wr(2'd3, 8'h01);
    idle(1);
    bus_rd(2'd2, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < (1<<AW); i++) model[i] = 8'h00;
    idle(3);
    rst = 1'b0;

    // R1 reset state (also R10 read path)
    bus_rd(2'd3, v); chk("R1 ctrl", v, ctrl_exp(0, 0, 0));
    bus_rd(2'd0, v); chk("R1 addr_lo", v, 8'h00);
    bus_rd(2'd2, v); chk("R1 data", v, 8'h00);

    // R2 address bytes, R10 select decode
    bus_wr(2'd0, 8'hA5); bus_wr(2'd1, 8'hFF);
    bus_rd(2'd1, v); chk("R2 addr_hi", v, 8'h01);
    bus_rd(2'd0, v); chk("R10 addr_lo", v, 8'hA5);

    // R3 arm window
    bus_wr(2'd3, 8'h04);
    idle(3);
    bus_rd(2'd3, v); chk("R3 arm live at edge 4", v, ctrl_exp(1, 0, 0));
    bus_rd(2'd3, v); chk("R3 arm expired", v, ctrl_exp(0, 0, 0));

    // R4 late go is ignored, in-window go launches
    set_addr(9'h010); bus_wr(2'd2, 8'h3C);
    bus_wr(2'd3, 8'h04); idle(4); bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, v); chk("R4 late go ignored", v, ctrl_exp(0, 0, 0));
    bus_wr(2'd3, 8'h04); idle(3); bus_wr(2'd3, 8'h02);
    model[9'h010] = 8'h3C;
    bus_rd(2'd3, v); chk("R4 launch busy, arm cleared", v, ctrl_exp(0, 1, 0));
    // R5 busy length
    idle(WC - 2);
    bus_rd(2'd3, v); chk("R5 busy last cycle", v, ctrl_exp(0, 1, 0));
    bus_rd(2'd3, v); chk("R5 busy cleared", v, ctrl_exp(0, 0, 0));
    load(9'h010, v); chk("R5 stored byte", v, 8'h3C);

    // R4 go without arm, go with arm in same byte
    bus_wr(2'd3, 8'h02);
    bus_rd(2'd3, v); chk("R4 no arm", v, ctrl_exp(0, 0, 0));
    bus_wr(2'd3, 8'h06);
    bus_rd(2'd3, v); chk("R4 both bits", v, ctrl_exp(1, 0, 0));
    idle(6);

    // R7, R8 accesses during busy
    launch_store(9'h1F0, 8'h77);
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd2, 8'h99);
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd3, v); chk("R7 read strobe dropped", v, ctrl_exp(0, 1, 0));
    idle(WC);
    bus_rd(2'd0, v); chk("R8 addr write ignored", v, 8'hF0);
    bus_rd(2'd2, v); chk("R7 data kept", v, 8'h77);
    load(9'h1F0, v); chk("R5 stored after busy", v, 8'h77);

    // R6 read pending flag
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd3, v); chk("R6 read flag", v, ctrl_exp(0, 0, 1));
    bus_rd(2'd3, v); chk("R6 read flag clears", v, ctrl_exp(0, 0, 0));

    // R9 reset mid-store
    launch_store(9'h0AB, 8'h5E);
    idle(3);
    rst = 1'b1; idle(2); rst = 1'b0;
    bus_rd(2'd3, v); chk("R9 busy after reset", v, ctrl_exp(0, 1, 0));
    idle(WC);
    load(9'h0AB, v); chk("R9 byte stored", v, 8'h5E);

    // random stores and loads, R5 R6
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [7:0] d = 8'($urandom);
      launch_store(a, d);
      idle(WC);
    end
    for (int i = 0; i < 24; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      load(a, v); chk("R6 random load", v, model[a]);
    end
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a = AW'($urandom);
      logic [7:0] d = 8'($urandom);
      launch_store(a, d);
      idle(WC);
      load(a, v); chk("R5 random roundtrip", v, d);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule